// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the slave end of a three-wire serial programming bus. All of its I/O is timed by the beam-crossing clock. A host raises the framing line. It then shifts a 13-bit command into the data-in line: a chip identifier, a register address and an operation code. The port compares the identifier with the chip's strapped ID. If they match, or if the command is a broadcast, it applies the operation to the addressed register. The operation can load the register from serial data that follows the command, fill it with ones, clear it, restore its power-up value, or shift its contents back out on the data-out line.

The register space has 32 addresses, and 23 of them hold storage. There are fourteen 8-bit bias and threshold registers, two per-pixel serpentine registers with one bit per pixel, and seven 2-bit control registers. Many chips share the bus. Broadcast commands let a host program every chip at once. Read-back is always point-to-point, so that two drivers never contend on the data-out line.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, addresses 0 to 13 hold (17*a+3) mod 256, where a is the address. Addresses 14 and 15 hold all zeros. Addresses 16 to 22 hold 2'b01. The data-out line is 0.
- R2: A command is framed by the framing line being high. It is 13 bits, each sampled on a rising clock edge, MSB first: chip ID (5 bits), then register address (5 bits), then operation code (3 bits). Only one register operation takes effect per command.
- R3: Write (code 001) takes the data bits that follow the command, MSB first. The register length is 8 bits for addresses 0 to 13, PIX_BITS for addresses 14 and 15, and 2 bits for addresses 16 to 22. The new value takes effect on the edge that samples the last data bit.
- R4: Set (code 010) makes every bit of the addressed register 1.
- R5: Clear (code 100) makes every bit of the addressed register 0.
- R6: Default (code 101) restores the addressed register to its R1 value.
- R7: Read (code 011) starts output after the edge that samples the 13th command bit. From then the data-out line carries the register MSB first, with one new bit after each later edge on which the framing line is high. After the last bit, it carries 0. Outside a read, the data-out line is 0.
- R8: Addresses 23 to 31 hold no storage. They read back as zeros, and writes to them have no effect.
- R9: A command executes when its chip ID equals the strap input or equals 5'b11111 (broadcast). A command with any other ID changes nothing.
- R10: A broadcast Read produces no output. The data-out line stays 0.
- R11: If the framing line falls before the last data bit of a Write, the register keeps its previous value.
- R12: Codes 000, 110 and 111 change no register.
- R13: Bits shifted after a Write's last data bit, within the same frame, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_id | input | 5 | Strapped identifier of this chip |
| cfg_ctl | input | 1 | Framing line, high during a command frame |
| cfg_din | input | 1 | Serial command and write data in |
| cfg_dout | output | 1 | Serial read-back data out |

## Verification
The bench builds the port with PIX_BITS set to 40. This keeps full-length serpentine writes, read-backs and aborts on the final data bit short enough to repeat many times. With that setting, the three register lengths (2, 8 and 40 bits) are all covered by random traffic. So are truncated and over-long write frames, broadcast and foreign-ID commands, and no-op codes. The strap is tied to ID 9, and a second ID of 20 stands in for another chip on the bus.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    localparam int ID_W       = 5;
    localparam int ADDR_W     = 5;
    localparam int INS_W      = 3;
    localparam int CMD_W      = ID_W + ADDR_W + INS_W;
    localparam int NUM_ADDR   = 1 << ADDR_W;
    localparam int DAC_CNT    = 14;
    localparam int SERP_LAST  = 15;
    localparam int IMPL_CNT   = 23;
    localparam int DAC_W      = 8;
    localparam int CTRL_W     = 2;

    localparam logic [ID_W-1:0]   BCAST_ID     = 5'h1F;
    localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 2'b01;

    typedef enum logic [INS_W-1:0] {
        OP_NOP     = 3'b000,
        OP_WRITE   = 3'b001,
        OP_SET     = 3'b010,
        OP_READ    = 3'b011,
        OP_CLEAR   = 3'b100,
        OP_DEFAULT = 3'b101
    } op_e;

    typedef struct packed {
        logic [ID_W-1:0]   chip;
        logic [ADDR_W-1:0] addr;
        logic [INS_W-1:0]  ins;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_DRAIN
    } frame_e;

    function automatic int reg_len(logic [ADDR_W-1:0] a, int pix);
        if (int'(a) < DAC_CNT)   return DAC_W;
        if (int'(a) <= SERP_LAST) return pix;
        if (int'(a) < IMPL_CNT)  return CTRL_W;
        return 0;
    endfunction

    function automatic logic [DAC_W-1:0] dac_default(logic [ADDR_W-1:0] a);
        return DAC_W'(int'(a) * 17 + 3);
    endfunction

endpackage

// File: rtl/scfg_frame_decoder.sv
module scfg_frame_decoder
    import scfg_pkg::*;
#(
    parameter int PIX_BITS = 256,
    localparam int MAXW = (PIX_BITS > DAC_W) ? PIX_BITS : DAC_W,
    localparam int CW   = $clog2(MAXW + 1) > 4 ? $clog2(MAXW + 1) : 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   chip_id,
    input  logic              sctl,
    input  logic              sin,
    input  logic [MAXW-1:0]   rd_word,
    output logic [ADDR_W-1:0] op_addr,
    output logic              wr_en,
    output logic              set_en,
    output logic              clr_en,
    output logic              def_en,
    output logic [MAXW-1:0]   wr_word,
    output logic              sout
);

    frame_e             state;
    logic [CW-1:0]      cnt;
    logic [CMD_W-2:0]   cmd_sr;
    logic [ADDR_W-1:0]  lat_addr;
    logic [MAXW-1:0]    shf;

    cmd_t  c_next;
    logic  last_cmd_bit;
    logic  impl;
    logic  addressed;
    logic  unicast;
    logic  last_wr_bit;
    int    wlen;
    int    rshift;

    always_comb begin
        c_next       = cmd_t'({cmd_sr, sin});
        last_cmd_bit = (state == ST_CMD) && sctl && (cnt == CW'(CMD_W - 1));
        impl         = int'(c_next.addr) < IMPL_CNT;
        unicast      = (c_next.chip == chip_id) && (c_next.chip != BCAST_ID);
        addressed    = impl && ((c_next.chip == chip_id) || (c_next.chip == BCAST_ID));
        wlen         = reg_len(lat_addr, PIX_BITS);
        rshift       = MAXW - reg_len(c_next.addr, PIX_BITS);
        last_wr_bit  = (state == ST_WDATA) && sctl && (cnt == CW'(wlen - 1));
        op_addr      = (state == ST_CMD) ? c_next.addr : lat_addr;
        set_en       = last_cmd_bit && addressed && (c_next.ins == OP_SET);
        clr_en       = last_cmd_bit && addressed && (c_next.ins == OP_CLEAR);
        def_en       = last_cmd_bit && addressed && (c_next.ins == OP_DEFAULT);
        wr_en        = last_wr_bit;
        wr_word      = {shf[MAXW-2:0], sin};
        sout         = (state == ST_RDATA) && shf[MAXW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_CMD;
            cnt      <= '0;
            cmd_sr   <= '0;
            lat_addr <= '0;
            shf      <= '0;
        end else if (!sctl) begin
            state <= ST_CMD;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_CMD: begin
                    cmd_sr <= {cmd_sr[CMD_W-3:0], sin};
                    cnt    <= cnt + 1'b1;
                    if (last_cmd_bit) begin
                        cnt      <= '0;
                        lat_addr <= c_next.addr;
                        state    <= ST_DRAIN;
                        if (c_next.ins == OP_WRITE && addressed) begin
                            state <= ST_WDATA;
                        end else if (c_next.ins == OP_READ && unicast) begin
                            state <= ST_RDATA;
                            shf   <= rd_word << rshift;
                        end
                    end
                end
                ST_WDATA: begin
                    shf <= {shf[MAXW-2:0], sin};
                    cnt <= cnt + 1'b1;
                    if (last_wr_bit) state <= ST_DRAIN;
                end
                ST_RDATA: shf <= {shf[MAXW-2:0], 1'b0};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank
    import scfg_pkg::*;
#(
    parameter int PIX_BITS = 256,
    localparam int MAXW = (PIX_BITS > DAC_W) ? PIX_BITS : DAC_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              wr_en,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic              def_en,
    input  logic [MAXW-1:0]   wr_word,
    output logic [MAXW-1:0]   rd_word
);

    logic [MAXW-1:0] rd_vec [NUM_ADDR];

    for (genvar a = 0; a < NUM_ADDR; a++) begin : g_addr
        localparam int LEN = reg_len(ADDR_W'(a), PIX_BITS);
        if (LEN == 0) begin : g_empty
            assign rd_vec[a] = '0;
        end else begin : g_reg
            logic [LEN-1:0] q;
            logic [LEN-1:0] q_def;
            logic           hit;

            if (a < DAC_CNT) begin : g_dac
                assign q_def = LEN'(dac_default(ADDR_W'(a)));
            end else if (a <= SERP_LAST) begin : g_serp
                assign q_def = '0;
            end else begin : g_ctrl
                assign q_def = LEN'(CTRL_DEFAULT);
            end

            assign hit = (op_addr == ADDR_W'(a));

            always_ff @(posedge clk) begin
                if (rst)                 q <= q_def;
                else if (hit && wr_en)   q <= wr_word[LEN-1:0];
                else if (hit && set_en)  q <= '1;
                else if (hit && clr_en)  q <= '0;
                else if (hit && def_en)  q <= q_def;
            end

            assign rd_vec[a] = MAXW'(q);
        end
    end

    assign rd_word = rd_vec[op_addr];

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scfg_pkg::*;
#(
    parameter int PIX_BITS = 256,
    localparam int MAXW = (PIX_BITS > DAC_W) ? PIX_BITS : DAC_W
)(
    input  logic            clk,
    input  logic            rst,
    input  logic [ID_W-1:0] chip_id,
    input  logic            cfg_ctl,
    input  logic            cfg_din,
    output logic            cfg_dout
);

    logic [ADDR_W-1:0] op_addr;
    logic              wr_en;
    logic              set_en;
    logic              clr_en;
    logic              def_en;
    logic [MAXW-1:0]   wr_word;
    logic [MAXW-1:0]   rd_word;

    scfg_frame_decoder #(.PIX_BITS(PIX_BITS)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .chip_id (chip_id),
        .sctl    (cfg_ctl),
        .sin     (cfg_din),
        .rd_word (rd_word),
        .op_addr (op_addr),
        .wr_en   (wr_en),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .def_en  (def_en),
        .wr_word (wr_word),
        .sout    (cfg_dout)
    );

    scfg_regbank #(.PIX_BITS(PIX_BITS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .op_addr (op_addr),
        .wr_en   (wr_en),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .def_en  (def_en),
        .wr_word (wr_word),
        .rd_word (rd_word)
    );

endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
    import scfg_pkg::*;
#(
    parameter int PIX_BITS = 256,
    localparam int MAXW = (PIX_BITS > DAC_W) ? PIX_BITS : DAC_W
)(
    input logic              clk,
    input logic              rst,
    input logic              sctl,
    input logic              sout,
    input logic [ADDR_W-1:0] op_addr,
    input logic              wr_en,
    input logic              set_en,
    input logic              clr_en,
    input logic              def_en,
    input logic [MAXW-1:0]   wr_word,
    input logic [MAXW-1:0]   rd_word
);

    function automatic logic [MAXW-1:0] ones_of(logic [ADDR_W-1:0] a);
        logic [MAXW-1:0] m;
        int n;
        n = reg_len(a, PIX_BITS);
        m = '0;
        for (int i = 0; i < MAXW; i++) if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [MAXW-1:0] def_of(logic [ADDR_W-1:0] a);
        if (int'(a) < DAC_CNT)    return MAXW'(dac_default(a));
        if (int'(a) <= SERP_LAST) return '0;
        if (int'(a) < IMPL_CNT)   return MAXW'(CTRL_DEFAULT);
        return '0;
    endfunction

    p_one_op_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, set_en, clr_en, def_en}));

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_word == ($past(wr_word) & ones_of(op_addr)));

    p_set_ones_r4: assert property (@(posedge clk) disable iff (rst)
        set_en |=> rd_word == ones_of(op_addr));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> rd_word == '0);

    p_default_r6: assert property (@(posedge clk) disable iff (rst)
        def_en |=> rd_word == def_of(op_addr));

    p_quiet_out_r7: assert property (@(posedge clk) disable iff (rst)
        !sctl |=> !sout);

    p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(op_addr) >= IMPL_CNT) |-> rd_word == '0);

    p_commit_in_frame_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> sctl);

endmodule

bind serial_cfg_port scfg_checker #(.PIX_BITS(PIX_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sctl    (cfg_ctl),
    .sout    (cfg_dout),
    .op_addr (op_addr),
    .wr_en   (wr_en),
    .set_en  (set_en),
    .clr_en  (clr_en),
    .def_en  (def_en),
    .wr_word (wr_word),
    .rd_word (rd_word)
);

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int PIX        = 40;
    localparam logic [4:0] OWN   = 5'd9;
    localparam logic [4:0] OTHER = 5'd20;
    localparam logic [4:0] BCAST = 5'd31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl = 1'b0;
    logic din = 1'b0;
    logic dout;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    logic [PIX-1:0] model [32];

    serial_cfg_port #(.PIX_BITS(PIX)) uut (
        .clk      (clk),
        .rst      (rst),
        .chip_id  (OWN),
        .cfg_ctl  (ctl),
        .cfg_din  (din),
        .cfg_dout (dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int b_len(int a);
        if (a < 14) return 8;
        if (a < 16) return PIX;
        if (a < 23) return 2;
        return 0;
    endfunction

    function automatic logic [PIX-1:0] b_mask(int a);
        logic [PIX-1:0] m = '0;
        for (int i = 0; i < b_len(a); i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [PIX-1:0] b_def(int a);
        if (a < 14) return PIX'((a * 17 + 3) % 256);
        if (a < 16) return '0;
        if (a < 23) return PIX'(1);
        return '0;
    endfunction

    task automatic check(string req, logic [PIX-1:0] act, logic [PIX-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        ctl = 1'b1;
        din = b;
    endtask

    task automatic send_cmd(logic [4:0] id, logic [4:0] addr, logic [2:0] ins);
        logic [12:0] w = {id, addr, ins};
        for (int i = 12; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic end_frame();
        @(negedge clk);
        ctl = 1'b0;
        din = 1'b0;
        @(negedge clk);
        check("R7 idle out", PIX'(dout), '0);
    endtask

    task automatic do_write(logic [4:0] id, int a, logic [PIX-1:0] data, int nbits);
        int len = b_len(a);
        send_cmd(id, 5'(a), 3'b001);
        for (int k = 0; k < nbits; k++)
            send_bit(k < len ? data[len-1-k] : 1'($urandom));
        end_frame();
        if ((id == OWN || id == BCAST) && a < 23 && nbits >= len)
            model[a] = data & b_mask(a);
    endtask

    task automatic do_simple(logic [4:0] id, int a, logic [2:0] ins);
        send_cmd(id, 5'(a), ins);
        send_bit(1'($urandom));
        end_frame();
        if ((id == OWN || id == BCAST) && a < 23) begin
            if (ins == 3'b010) model[a] = b_mask(a);
            if (ins == 3'b100) model[a] = '0;
            if (ins == 3'b101) model[a] = b_def(a);
        end
    endtask

    task automatic do_read(string req, int a);
        logic [PIX-1:0] got = '0;
        logic tail = 1'b0;
        int len = b_len(a);
        send_cmd(OWN, 5'(a), 3'b011);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            got = {got[PIX-2:0], dout};
            din = 1'b0;
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            tail = tail | dout;
        end
        end_frame();
        check(req, got, model[a]);
        check("R7 trailing zeros", PIX'(tail), '0);
    endtask

    task automatic do_bcast_read(int a);
        logic seen = 1'b0;
        send_cmd(BCAST, 5'(a), 3'b011);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            seen = seen | dout;
        end
        end_frame();
        check("R10 broadcast read silent", PIX'(seen), '0);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd4242));
        for (int a = 0; a < 32; a++) model[a] = b_def(a);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset out", PIX'(dout), '0);

        // R1: every address after reset
        for (int a = 0; a < 32; a++) do_read("R1 reset value", a);

        // R3 / R2: directed writes at each length
        do_write(OWN, 3, PIX'(8'hA5), 8);
        do_read("R3 dac write", 3);
        do_write(OWN, 14, 40'hF0_1234_5678, PIX);
        do_read("R3 serpentine write", 14);
        do_write(OWN, 20, PIX'(2'b10), 2);
        do_read("R3 ctrl write", 20);

        // R11: abort one bit short
        do_write(OWN, 15, 40'hAB_CDEF_0123, PIX - 1);
        do_read("R11 abort keeps old", 15);
        // R13: extra bits after completion
        do_write(OWN, 5, PIX'(8'h3C), 14);
        do_read("R13 extra bits ignored", 5);

        // R4, R5, R6
        do_simple(OWN, 15, 3'b010);
        do_read("R4 set ones", 15);
        do_simple(OWN, 5, 3'b100);
        do_read("R5 clear", 5);
        do_simple(OWN, 5, 3'b101);
        do_read("R6 default", 5);

        // R8 unimplemented
        do_write(OWN, 27, PIX'(8'hFF), 8);
        do_simple(OWN, 30, 3'b010);
        do_read("R8 hole zero", 27);
        do_read("R8 hole zero", 30);

        // R9 broadcast and foreign ID
        do_write(BCAST, 7, PIX'(8'h5A), 8);
        do_read("R9 broadcast write", 7);
        do_write(OTHER, 7, PIX'(8'h11), 8);
        do_simple(OTHER, 14, 3'b100);
        do_read("R9 foreign ignored", 7);
        do_read("R9 foreign ignored", 14);

        // R10
        do_bcast_read(7);

        // R12 no-op codes
        do_simple(OWN, 3, 3'b000);
        do_simple(OWN, 3, 3'b110);
        do_simple(OWN, 3, 3'b111);
        do_read("R12 no-op codes", 3);

        // constrained random traffic
        for (int n = 0; n < 300; n++) begin
            int a = int'($urandom_range(0, 31));
            int sel = int'($urandom_range(0, 9));
            logic [4:0] id = (sel < 6) ? OWN : (sel < 8) ? BCAST : OTHER;
            logic [2:0] ins = 3'($urandom_range(0, 7));
            logic [PIX-1:0] data = {8'($urandom), 32'($urandom)};
            if (ins == 3'b001) begin
                int r = int'($urandom_range(0, 3));
                int nb = (r == 0) ? int'($urandom_range(0, b_len(a))) :
                         (r == 1) ? b_len(a) + 3 : b_len(a);
                do_write(id, a, data, nb);
            end else if (ins == 3'b011) begin
                if (id == BCAST) do_bcast_read(a);
                else do_read("R2 random read", a);
            end else begin
                do_simple(id, a, ins);
            end
        end

        for (int a = 0; a < 32; a++) do_read("R3 final sweep", a);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule